// File: doc/BRIEF.md
# Serial NOR Flash Device Emulator

This block plays the device side of a single-lane serial NOR flash in SPI mode 0. It samples the four SPI pins with its own system clock and decodes the command byte that opens each chip-select window. A byte array held inside the block stands in for the flash cells and starts out erased. A host controller can read, fast-read, program pages, erase sectors, poll the status byte and fetch an identification code, all as it would with a real part.

Program and erase follow the usual flash rules. The write-enable latch must be set before either is accepted. Programming only clears bits. An erased sector reads all ones. After the chip select rises, a busy window opens, and its length is a count of system clocks. During that window only the status poll is served, and the latch drops when the window closes. Each sector is cleared one byte per clock inside the same window, so the erase time must be at least the sector size.

The SPI clock must be slow enough that each of its phases lasts at least four system clocks, because every pin passes through a two-stage synchroniser.

Top module: `spi_flash_emu`

## Requirements
- R1: Mode 0 is used. MOSI is taken on the rising SCK edge and MISO changes only after a falling SCK edge, most significant bit first. MISO is 0 whenever chip select is high.
- R2: Opcode 03h takes a 24-bit address in three bytes, high byte first, and then returns data from that address. The address increments after every byte while chip select stays low. Only the low log2(MEM_BYTES) address bits select the byte, so reads wrap from the last byte to byte 0.
- R3: Opcode 0Bh works like 03h except that one dummy byte follows the address before the first data byte.
- R4: Opcode 06h sets the write-enable latch and opcode 04h clears it.
- R5: Opcode 02h with a 24-bit address and data bytes is accepted only when the latch is set. When the latch is clear, no byte changes and no busy window starts.
- R6: Each programmed byte becomes old AND new. The byte address advances within one PAGE_BYTES page and wraps to the start of that same page.
- R7: Opcode 05h returns a status byte on every byte slot while chip select is low. Bit 0 is write-in-progress, bit 1 is the write-enable latch, and bits 7..2 are 0. The value is refreshed for every byte.
- R8: When chip select rises after an accepted program or erase, write-in-progress is set. It stays set for PROG_CYCLES or ERASE_CYCLES system clocks, and the write-enable latch clears in the same cycle that write-in-progress clears.
- R9: While write-in-progress is 1, every opcode other than 05h is ignored. Its data slots return 00h and it changes neither memory nor the latch.
- R10: Opcode 9Fh returns the three bytes of ID_CODE, high byte first, and 00h for every slot after them.
- R11: Opcode 20h with a 24-bit address, sent while the latch is set, sets every byte of the aligned SECTOR_BYTES sector that contains the address to FFh and leaves other sectors unchanged. Without the latch it does nothing.
- R12: After reset the status byte is 00h and every memory byte reads FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI serial clock from the host, idle low |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |

## Verification
Two events can fall in the same clock. One is the end of the busy window, which clears write-in-progress and the write-enable latch together. The other is the reload of the status byte during a long 05h poll. The bench provokes this by streaming status bytes without releasing chip select across the end of a program. It accepts only a run of 03h followed by a run of 00h, and it fails any 01h or 02h, which would mean the two bits were cleared in different cycles. Commands sent inside a busy window, with the latch still set, are also judged. For these the bench reads memory back afterwards to show that the ignored program left its target unchanged.

// File: rtl/fe_pkg.sv
package fe_pkg;
    typedef enum logic [2:0] {
        PH_OPC,
        PH_ADDR,
        PH_DUMMY,
        PH_DATA,
        PH_SKIP
    } phase_e;

    localparam logic [7:0] OP_READ   = 8'h03;
    localparam logic [7:0] OP_FREAD  = 8'h0B;
    localparam logic [7:0] OP_PROG   = 8'h02;
    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_WRDI   = 8'h04;
    localparam logic [7:0] OP_RDSR   = 8'h05;
    localparam logic [7:0] OP_RDID   = 8'h9F;
    localparam logic [7:0] OP_SERASE = 8'h20;
endpackage

// File: rtl/fe_pin_sync.sv
module fe_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic sck_rise,
    output logic sck_fall,
    output logic sel,
    output logic mosi_s
);
    logic [STAGES-1:0] sck_q, cs_q, mo_q;
    logic              sck_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q      <= '0;
            cs_q       <= '1;
            mo_q       <= '0;
            sck_prev_q <= 1'b0;
        end else begin
            sck_q      <= {sck_q[STAGES-2:0], sck};
            cs_q       <= {cs_q[STAGES-2:0], cs_n};
            mo_q       <= {mo_q[STAGES-2:0], mosi};
            sck_prev_q <= sck_q[STAGES-1];
        end
    end

    assign sel      = ~cs_q[STAGES-1];
    assign mosi_s   = mo_q[STAGES-1];
    assign sck_rise = sel &  sck_q[STAGES-1] & ~sck_prev_q;
    assign sck_fall = sel & ~sck_q[STAGES-1] &  sck_prev_q;
endmodule

// File: rtl/fe_busy_timer.sv
module fe_busy_timer #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] load,
    output logic          active
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = load;
        else if (cnt_q != '0)
            cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign active = (cnt_q != '0);
endmodule

// File: rtl/fe_mem.sv
module fe_mem #(
    parameter int DEPTH = 4096,
    parameter int AW    = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] cell_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cell_q[i] <= 8'hFF;
        end else if (we) begin
            cell_q[waddr] <= wdata;
        end
    end

    assign rdata = cell_q[raddr];
endmodule

// File: rtl/spi_flash_emu.sv
module spi_flash_emu #(
    parameter int          MEM_BYTES    = 4096,
    parameter int          PAGE_BYTES   = 256,
    parameter int          SECTOR_BYTES = 1024,
    parameter int          PROG_CYCLES  = 2000,
    parameter int          ERASE_CYCLES = 8000,
    parameter logic [23:0] ID_CODE      = 24'hA5_40_0C
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic miso
);
    import fe_pkg::*;

    localparam int AW   = $clog2(MEM_BYTES);
    localparam int PW   = $clog2(PAGE_BYTES);
    localparam int SW   = $clog2(SECTOR_BYTES);
    localparam int MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        phase_e        ph;
        logic [7:0]    opc;
        logic [2:0]    nbit;
        logic [7:0]    rxs;
        logic [23:0]   addr;
        logic [1:0]    nadr;
        logic [7:0]    txs;
        logic          miso;
        logic          act;
        logic          wel;
        logic          wip;
        logic [1:0]    idn;
        logic          prog_pend;
        logic          erase_pend;
        logic          erasing;
        logic [SW-1:0] eidx;
        logic [AW-1:0] ebase;
    } st_t;

    st_t s_d, s_q;

    logic          sck_rise, sck_fall, sel, mosi_s;
    logic          mem_we;
    logic [AW-1:0] mem_wa, mem_ra;
    logic [7:0]    mem_wd, mem_rd;
    logic          tmr_start, tmr_active;
    logic [CW-1:0] tmr_load;
    logic [7:0]    byte_in, status;
    logic [23:0]   new_addr;
    logic          wip_s, wel_s;

    fe_pin_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .cs_n     (cs_n),
        .mosi     (mosi),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .sel      (sel),
        .mosi_s   (mosi_s)
    );

    fe_mem #(.DEPTH(MEM_BYTES), .AW(AW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_wa),
        .wdata (mem_wd),
        .raddr (mem_ra),
        .rdata (mem_rd)
    );

    fe_busy_timer #(.CW(CW)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tmr_start),
        .load   (tmr_load),
        .active (tmr_active)
    );

    assign byte_in  = {s_q.rxs[6:0], mosi_s};
    assign status   = {6'b0, s_q.wel, s_q.wip};
    assign new_addr = {s_q.addr[15:0], byte_in};

    always_comb begin
        s_d       = s_q;
        mem_we    = 1'b0;
        mem_wa    = '0;
        mem_wd    = 8'h00;
        mem_ra    = s_q.addr[AW-1:0];
        tmr_start = 1'b0;
        tmr_load  = '0;
        s_d.act   = sel;

        // sector clear walks one byte per clock inside the busy window
        if (s_q.erasing) begin
            mem_we   = 1'b1;
            mem_wa   = s_q.ebase | AW'(s_q.eidx);
            mem_wd   = 8'hFF;
            s_d.eidx = s_q.eidx + SW'(1);
            if (s_q.eidx == '1) s_d.erasing = 1'b0;
        end

        if (s_q.wip && !tmr_active && !s_q.erasing) begin
            s_d.wip = 1'b0;
            s_d.wel = 1'b0;
        end

        if (!sel) begin
            s_d.ph   = PH_OPC;
            s_d.nbit = 3'd0;
            s_d.nadr = 2'd0;
            s_d.txs  = 8'h00;
            s_d.miso = 1'b0;
            s_d.idn  = 2'd0;
            if (s_q.act) begin
                if (s_q.prog_pend) begin
                    s_d.wip   = 1'b1;
                    tmr_start = 1'b1;
                    tmr_load  = CW'(PROG_CYCLES);
                end else if (s_q.erase_pend) begin
                    s_d.wip     = 1'b1;
                    s_d.erasing = 1'b1;
                    s_d.eidx    = '0;
                    tmr_start   = 1'b1;
                    tmr_load    = CW'(ERASE_CYCLES);
                end
                s_d.prog_pend  = 1'b0;
                s_d.erase_pend = 1'b0;
            end
        end else begin
            if (sck_fall) begin
                s_d.miso = s_q.txs[7];
                s_d.txs  = {s_q.txs[6:0], 1'b0};
            end
            if (sck_rise) begin
                s_d.rxs  = byte_in;
                s_d.nbit = s_q.nbit + 3'd1;
                if (s_q.nbit == 3'd7) begin
                    unique case (s_q.ph)
                        PH_OPC: begin
                            s_d.opc  = byte_in;
                            s_d.nadr = 2'd0;
                            s_d.ph   = PH_SKIP;
                            if (!s_q.wip || byte_in == OP_RDSR) begin
                                case (byte_in)
                                    OP_READ, OP_FREAD: s_d.ph = PH_ADDR;
                                    OP_PROG, OP_SERASE:
                                        if (s_q.wel) s_d.ph = PH_ADDR;
                                    OP_WREN: s_d.wel = 1'b1;
                                    OP_WRDI: s_d.wel = 1'b0;
                                    OP_RDSR: begin
                                        s_d.ph  = PH_DATA;
                                        s_d.txs = status;
                                    end
                                    OP_RDID: begin
                                        s_d.ph  = PH_DATA;
                                        s_d.txs = ID_CODE[23:16];
                                        s_d.idn = 2'd1;
                                    end
                                    default: s_d.ph = PH_SKIP;
                                endcase
                            end
                        end
                        PH_ADDR: begin
                            s_d.addr = new_addr;
                            s_d.nadr = s_q.nadr + 2'd1;
                            if (s_q.nadr == 2'd2) begin
                                case (s_q.opc)
                                    OP_READ: begin
                                        mem_ra   = new_addr[AW-1:0];
                                        s_d.txs  = mem_rd;
                                        s_d.addr = new_addr + 24'd1;
                                        s_d.ph   = PH_DATA;
                                    end
                                    OP_FREAD: s_d.ph = PH_DUMMY;
                                    OP_PROG:  s_d.ph = PH_DATA;
                                    default: begin
                                        s_d.erase_pend = 1'b1;
                                        s_d.ebase = new_addr[AW-1:0] & ~AW'(SECTOR_BYTES - 1);
                                        s_d.ph    = PH_SKIP;
                                    end
                                endcase
                            end
                        end
                        PH_DUMMY: begin
                            s_d.txs  = mem_rd;
                            s_d.addr = s_q.addr + 24'd1;
                            s_d.ph   = PH_DATA;
                        end
                        PH_DATA: begin
                            case (s_q.opc)
                                OP_READ, OP_FREAD: begin
                                    s_d.txs  = mem_rd;
                                    s_d.addr = s_q.addr + 24'd1;
                                end
                                OP_RDSR: s_d.txs = status;
                                OP_RDID: begin
                                    case (s_q.idn)
                                        2'd1:    s_d.txs = ID_CODE[15:8];
                                        2'd2:    s_d.txs = ID_CODE[7:0];
                                        default: s_d.txs = 8'h00;
                                    endcase
                                    if (s_q.idn != 2'd3) s_d.idn = s_q.idn + 2'd1;
                                end
                                default: begin
                                    mem_we        = 1'b1;
                                    mem_wa        = s_q.addr[AW-1:0];
                                    mem_wd        = mem_rd & byte_in;
                                    s_d.prog_pend = 1'b1;
                                    s_d.addr      = {s_q.addr[23:PW], s_q.addr[PW-1:0] + PW'(1)};
                                end
                            endcase
                        end
                        default: s_d.ph = PH_SKIP;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.ph    <= PH_OPC;
        end else begin
            s_q <= s_d;
        end
    end

    assign miso  = s_q.miso;
    assign wip_s = s_q.wip;
    assign wel_s = s_q.wel;
endmodule

// File: rtl/fe_checker.sv
module fe_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wip,
    input logic       wel,
    input logic       mem_we,
    input logic [7:0] mem_wd,
    input logic [7:0] mem_rd,
    input logic       miso,
    input logic       sck_fall,
    input logic       sel
);
    a_r1_miso_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(miso) |-> ($past(sck_fall) || !$past(sel)));

    a_r5_prog_write_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !wip) |-> wel);

    a_r6_program_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !wip) |-> ((mem_wd & ~mem_rd) == 8'h00));

    a_r8_wel_drops_with_wip: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> !wel);

    a_r9_no_wel_rise_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (wip && $past(wip)) |-> !(wel && !$past(wel)));

    a_r11_erase_writes_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && wip) |-> (mem_wd == 8'hFF));
endmodule

bind spi_flash_emu fe_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wip      (wip_s),
    .wel      (wel_s),
    .mem_we   (mem_we),
    .mem_wd   (mem_wd),
    .mem_rd   (mem_rd),
    .miso     (miso),
    .sck_fall (sck_fall),
    .sel      (sel)
);

// File: tb/tb_spi_flash_emu.sv
`timescale 1ns/1ps
module tb_spi_flash_emu;
    localparam int MEM = 1024;
    localparam int PG  = 256;
    localparam int SEC = 512;
    localparam int H   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [MEM];

    always #4 clk = ~clk;

    spi_flash_emu #(
        .MEM_BYTES(MEM), .PAGE_BYTES(PG), .SECTOR_BYTES(SEC),
        .PROG_CYCLES(1000), .ERASE_CYCLES(1200), .ID_CODE(24'hA5_40_0C)
    ) dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %02h exp %02h", tag, got, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            repeat (H) @(negedge clk);
            rx[i] = miso;
            sck = 1'b1;
            repeat (H) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic sel_on();
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
    endtask

    task automatic sel_off();
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        repeat (4 * H) @(negedge clk);
    endtask

    task automatic hdr(input logic [7:0] op, input logic [23:0] a);
        logic [7:0] r;
        xfer(op, r);
        xfer(a[23:16], r);
        xfer(a[15:8], r);
        xfer(a[7:0], r);
    endtask

    task automatic one_op(input logic [7:0] op);
        logic [7:0] r;
        sel_on();
        xfer(op, r);
        sel_off();
    endtask

    task automatic rd_status(output logic [7:0] st);
        logic [7:0] r;
        sel_on();
        xfer(8'h05, r);
        xfer(8'h00, st);
        sel_off();
    endtask

    task automatic wait_idle(input string tag);
        logic [7:0] r;
        int n;
        sel_on();
        xfer(8'h05, r);
        n = 0;
        do begin
            xfer(8'h00, r);
            n++;
        end while (r[0] && n < 200);
        sel_off();
        chk(tag, r, 8'h00);
    endtask

    task automatic rd_cmp(input logic [7:0] op, input logic [23:0] a, input int n, input string tag);
        logic [7:0] r;
        sel_on();
        hdr(op, a);
        if (op == 8'h0B) xfer(8'h00, r);
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, r);
            chk(tag, r, model[(int'(a) + k) % MEM]);
        end
        sel_off();
    endtask

    task automatic prog(input logic [23:0] a, input logic [7:0] d []);
        logic [7:0] r;
        sel_on();
        hdr(8'h02, a);
        foreach (d[k]) xfer(d[k], r);
        sel_off();
    endtask

    function automatic void model_prog(input int a, input logic [7:0] d []);
        foreach (d[k]) begin
            int idx;
            idx = ((a % MEM) & ~(PG - 1)) | ((a + k) & (PG - 1));
            model[idx] = model[idx] & d[k];
        end
    endfunction

    initial begin
        repeat (195000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] st, r;
        logic [7:0] d [];
        bit seen_idle, bad;
        for (int i = 0; i < MEM; i++) model[i] = 8'hFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R12 reset state, R1 idle miso
        chk("R1 miso idle", {7'b0, miso}, 8'h00);
        rd_status(st);
        chk("R12 status after reset", st, 8'h00);
        rd_cmp(8'h03, 24'h000000, 2, "R12 erased after reset");

        // R10 identification
        sel_on();
        xfer(8'h9F, r);
        xfer(8'h00, r); chk("R10 id0", r, 8'hA5);
        xfer(8'h00, r); chk("R10 id1", r, 8'h40);
        xfer(8'h00, r); chk("R10 id2", r, 8'h0C);
        xfer(8'h00, r); chk("R10 tail", r, 8'h00);
        sel_off();

        // R5 program without latch
        d = '{8'h12};
        prog(24'h000010, d);
        rd_status(st);
        chk("R5 no busy without latch", st, 8'h00);
        rd_cmp(8'h03, 24'h000010, 1, "R5 byte unchanged");

        // R4 latch set and clear
        one_op(8'h06);
        rd_status(st);
        chk("R4 latch set", st, 8'h02);
        one_op(8'h04);
        rd_status(st);
        chk("R4 latch cleared", st, 8'h00);

        // R6 page wrap, R9 ignored read, R7/R8 streamed status
        one_op(8'h06);
        d = '{8'hA1, 8'hA2, 8'hA3, 8'hA4};
        prog(24'h0000FE, d);
        model_prog(32'h0FE, d);
        sel_on();
        hdr(8'h03, 24'h000010);
        xfer(8'h00, r);
        sel_off();
        chk("R9 read ignored while busy", r, 8'h00);
        sel_on();
        xfer(8'h05, r);
        xfer(8'h00, r);
        chk("R8 busy right after program", r, 8'h03);
        seen_idle = 1'b0;
        bad = 1'b0;
        for (int k = 0; k < 40; k++) begin
            xfer(8'h00, r);
            if (r == 8'h00) seen_idle = 1'b1;
            else if (r != 8'h03 || seen_idle) bad = 1'b1;
        end
        sel_off();
        chk("R7 status stream only 03 then 00", {6'b0, bad, seen_idle}, 8'h01);
        rd_status(st);
        chk("R8 latch cleared at end", st, 8'h00);

        // R2 auto increment across a page, upper address bits ignored
        rd_cmp(8'h03, 24'h0000FC, 6, "R6 wrap contents / R2 increment");
        rd_cmp(8'h03, 24'h000400, 2, "R2 upper bits ignored");

        // R6 AND semantics
        one_op(8'h06);
        d = '{8'h0F};
        prog(24'h000001, d);
        model_prog(1, d);
        wait_idle("R8 idle after program");
        rd_cmp(8'h03, 24'h000001, 1, "R6 and with old");

        // R3 fast read, R2 end-of-array wrap
        rd_cmp(8'h0B, 24'h000000, 2, "R3 fast read");
        rd_cmp(8'h03, 24'h0003FF, 2, "R2 wrap at end");

        // R11 erase, R9 program ignored while busy
        one_op(8'h06);
        d = '{8'h5A};
        prog(24'h000300, d);
        model_prog(32'h300, d);
        wait_idle("R8 idle");
        one_op(8'h06);
        sel_on();
        hdr(8'h20, 24'h000123);
        sel_off();
        d = '{8'h00};
        prog(24'h000300, d);
        wait_idle("R8 idle after erase");
        for (int i = 0; i < SEC; i++) model[i] = 8'hFF;
        rd_cmp(8'h03, 24'h0000FE, 4, "R11 sector erased");
        rd_cmp(8'h03, 24'h000300, 1, "R9 program ignored / R11 other sector kept");
        sel_on();
        hdr(8'h20, 24'h000300);
        sel_off();
        rd_status(st);
        chk("R11 erase without latch no busy", st, 8'h00);
        rd_cmp(8'h03, 24'h000300, 1, "R11 erase without latch");

        // full page sweep
        one_op(8'h06);
        d = new[PG];
        for (int k = 0; k < PG; k++) d[k] = 8'((k * 7 + 3) & 8'hFF);
        prog(24'h000200, d);
        model_prog(32'h200, d);
        wait_idle("R8 idle after page");
        rd_cmp(8'h03, 24'h000180, 640, "R2 R6 sweep");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule